// File: doc/BRIEF.md
# Storage PHY Power Sequencer

This block takes the analog front end of a storage-interface PHY through its power-down and power-up steps without software involvement. It accepts a power-on or a power-off command. It counts time in pulses from an external microsecond tick and an external millisecond tick. It drives four controls: the internal clock enable, the clock output enable, the active-high pad power enable (the inverse of a power-down signal) and the DLL enable. It reads three status lines from the PHY: clock ready, calibration done and DLL ready.

Every command first removes pad power and the DLL enable. A power-off command ends there. A power-on command then works through three stages in a fixed order. First it starts the internal clock and waits for clock ready. Then it enables the clock output and powers the pads, after which calibration is checked. Finally it enables the DLL and checks DLL ready. Each later stage waits a fixed number of ticks and then samples its status input exactly once. The clock stage is the exception: it polls clock ready on each millisecond tick up to a limit. At the end of a sequence the block gives a one-cycle done pulse. In the same cycle it presents a 2-bit result code.

Top module: `phy_pwr_seq`

## Requirements
- R1: A power-off command (`start_off`) accepted while idle clears `pad_pwr_o` and `dll_en_o` at the next clock edge. In the cycle after acceptance `done_o` is 1 with `err_o` = 0, and `busy_o` stays 0. The clock enables keep their values.
- R2: A power-on command (`start_on`) accepted while idle clears `pad_pwr_o` and `dll_en_o` and raises `busy_o` at the next edge. `int_clk_en_o` rises one cycle later.
- R3: While waiting for the clock, `clk_rdy_i` is sampled only in cycles where `tick_ms` is high. If it is low on `CLK_POLLS` (default 20) consecutive such samples, the sequence ends with `err_o` = 1 (clock timeout).
- R4: The first `tick_ms` that sees `clk_rdy_i` high sets `clk_out_en_o` at the next edge. `pad_pwr_o` stays low until the `PDB_TICKS`-th (default 3) `tick_us` pulse after that point, and rises at the edge that samples that pulse.
- R5: After pad power rises, `cal_done_i` is sampled only on the `CAL_TICKS`-th (default 5) `tick_us` pulse. If it is low, the sequence ends with `err_o` = 2 (calibration timeout).
- R6: When calibration succeeds, `dll_en_o` rises and `dll_rdy_i` is sampled only on the `DLL_TICKS`-th (default 30) `tick_us` pulse. High ends the sequence with `err_o` = 0; low ends it with `err_o` = 3 (DLL timeout).
- R7: `start_on` and `start_off` have no effect while `busy_o` is 1. The outputs and the sequence continue unchanged.
- R8: `done_o` is high for one cycle per finished sequence, and `busy_o` is 0 in that cycle. `err_o` is valid in that cycle, with code 0 meaning success.
- R9: When a sequence ends with an error, `pad_pwr_o` and `dll_en_o` are low. `int_clk_en_o` and `clk_out_en_o` keep their last values.
- R10: If `start_on` and `start_off` are both high while idle, the power-off command is taken.
- R11: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_on | input | 1 | Power-on command, sampled while idle |
| start_off | input | 1 | Power-off command, sampled while idle |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| clk_rdy_i | input | 1 | PHY internal clock is stable |
| cal_done_i | input | 1 | PHY pad calibration finished |
| dll_rdy_i | input | 1 | PHY DLL is locked |
| int_clk_en_o | output | 1 | Internal clock enable |
| clk_out_en_o | output | 1 | Clock output enable |
| pad_pwr_o | output | 1 | Pad power enable, active high (power-down bar) |
| dll_en_o | output | 1 | DLL enable |
| busy_o | output | 1 | Power-on sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| err_o | output | 2 | Result: 0 ok, 1 clock, 2 calibration, 3 DLL timeout |

## Verification
Power-on sequences vary the millisecond tick on which clock ready first appears, from the first poll through the last allowed poll and beyond it. This separates an off-by-one in the poll limit from a correct timeout. The calibration and DLL status lines are driven to the wrong level on every tick except the sampling tick. Because of this, a stage that samples early or late gives a wrong result code. Random gaps between ticks confirm that the waits count ticks and not clock cycles. Stray commands during a sequence, off commands after a powered-up state, and simultaneous on and off commands show that commands are ignored while busy and that power-off has priority.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CLKEN,
        S_CLKPOLL,
        S_PADWAIT,
        S_CALWAIT,
        S_DLLWAIT
    } seq_state_e;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_CLK_TO  = 2'd1,
        RES_CAL_TO  = 2'd2,
        RES_DLL_TO  = 2'd3
    } seq_res_e;

    typedef struct packed {
        seq_state_e state;
        logic       int_clk_en;
        logic       clk_out_en;
        logic       pad_pwr;
        logic       dll_en;
        logic       busy;
        logic       done;
        seq_res_e   res;
    } seq_regs_t;

endpackage

// File: rtl/pwrseq_tick_timer.sv
module pwrseq_tick_timer #(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             use_ms,
    input  logic             tick_us,
    input  logic             tick_ms,
    input  logic [CNT_W-1:0] limit,
    output logic             tick_o,
    output logic             hit_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign tick_o = use_ms ? tick_ms : tick_us;
    assign hit_o  = tick_o && (cnt_q == limit - 1'b1);

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (tick_o) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (limit != '0) |-> (cnt_q < limit)); // R3

endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
    import pwrseq_pkg::*;
#(
    parameter int unsigned CNT_W     = 5,
    parameter int unsigned CLK_POLLS = 20,
    parameter int unsigned PDB_TICKS = 3,
    parameter int unsigned CAL_TICKS = 5,
    parameter int unsigned DLL_TICKS = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_on,
    input  logic             start_off,
    input  logic             tick,
    input  logic             hit,
    input  logic             clk_rdy_i,
    input  logic             cal_done_i,
    input  logic             dll_rdy_i,
    output logic             tmr_clr,
    output logic             tmr_use_ms,
    output logic [CNT_W-1:0] tmr_limit,
    output logic             int_clk_en_o,
    output logic             clk_out_en_o,
    output logic             pad_pwr_o,
    output logic             dll_en_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [1:0]       err_o
);

    localparam logic [CNT_W-1:0] LIM_POLL = CNT_W'(CLK_POLLS);
    localparam logic [CNT_W-1:0] LIM_PDB  = CNT_W'(PDB_TICKS);
    localparam logic [CNT_W-1:0] LIM_CAL  = CNT_W'(CAL_TICKS);
    localparam logic [CNT_W-1:0] LIM_DLL  = CNT_W'(DLL_TICKS);

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        tmr_clr    = 1'b0;
        tmr_use_ms = 1'b0;
        tmr_limit  = '0;
        unique case (r_q.state)
            S_IDLE: begin
                tmr_clr = 1'b1;
                if (start_off) begin
                    r_d.pad_pwr = 1'b0;
                    r_d.dll_en  = 1'b0;
                    r_d.done    = 1'b1;
                    r_d.res     = RES_OK;
                end else if (start_on) begin
                    r_d.pad_pwr = 1'b0;
                    r_d.dll_en  = 1'b0;
                    r_d.busy    = 1'b1;
                    r_d.res     = RES_OK;
                    r_d.state   = S_CLKEN;
                end
            end
            S_CLKEN: begin
                tmr_clr        = 1'b1;
                r_d.int_clk_en = 1'b1;
                r_d.state      = S_CLKPOLL;
            end
            S_CLKPOLL: begin
                tmr_use_ms = 1'b1;
                tmr_limit  = LIM_POLL;
                if (tick && clk_rdy_i) begin
                    tmr_clr        = 1'b1;
                    r_d.clk_out_en = 1'b1;
                    r_d.state      = S_PADWAIT;
                end else if (hit) begin
                    tmr_clr     = 1'b1;
                    r_d.pad_pwr = 1'b0;
                    r_d.dll_en  = 1'b0;
                    r_d.busy    = 1'b0;
                    r_d.done    = 1'b1;
                    r_d.res     = RES_CLK_TO;
                    r_d.state   = S_IDLE;
                end
            end
            S_PADWAIT: begin
                tmr_limit = LIM_PDB;
                if (hit) begin
                    tmr_clr     = 1'b1;
                    r_d.pad_pwr = 1'b1;
                    r_d.state   = S_CALWAIT;
                end
            end
            S_CALWAIT: begin
                tmr_limit = LIM_CAL;
                if (hit) begin
                    tmr_clr = 1'b1;
                    if (cal_done_i) begin
                        r_d.dll_en = 1'b1;
                        r_d.state  = S_DLLWAIT;
                    end else begin
                        r_d.pad_pwr = 1'b0;
                        r_d.dll_en  = 1'b0;
                        r_d.busy    = 1'b0;
                        r_d.done    = 1'b1;
                        r_d.res     = RES_CAL_TO;
                        r_d.state   = S_IDLE;
                    end
                end
            end
            S_DLLWAIT: begin
                tmr_limit = LIM_DLL;
                if (hit) begin
                    tmr_clr   = 1'b1;
                    r_d.busy  = 1'b0;
                    r_d.done  = 1'b1;
                    r_d.state = S_IDLE;
                    if (dll_rdy_i) begin
                        r_d.res = RES_OK;
                    end else begin
                        r_d.pad_pwr = 1'b0;
                        r_d.dll_en  = 1'b0;
                        r_d.res     = RES_DLL_TO;
                    end
                end
            end
            default: begin
                tmr_clr   = 1'b1;
                r_d.state = S_IDLE;
                r_d.busy  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: S_IDLE, res: RES_OK, default: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign int_clk_en_o = r_q.int_clk_en;
    assign clk_out_en_o = r_q.clk_out_en;
    assign pad_pwr_o    = r_q.pad_pwr;
    assign dll_en_o     = r_q.dll_en;
    assign busy_o       = r_q.busy;
    assign done_o       = r_q.done;
    assign err_o        = r_q.res;

    AST_OFF_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_off) |=> (done_o && err_o == 2'd0 && !busy_o && !pad_pwr_o && !dll_en_o)); // R1

    AST_ON_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_on && !start_off) |=> (busy_o && !pad_pwr_o && !dll_en_o)); // R2

    AST_PAD_AFTER_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        pad_pwr_o |-> (clk_out_en_o && int_clk_en_o)); // R4

    AST_DLL_AFTER_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        dll_en_o |-> pad_pwr_o); // R6

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R8

    AST_ERR_SAFE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o != 2'd0) |-> (!pad_pwr_o && !dll_en_o)); // R9

    AST_BUSY_HOLDS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && int_clk_en_o) |=> int_clk_en_o); // R7

endmodule

// File: rtl/phy_pwr_seq.sv
module phy_pwr_seq #(
    parameter int unsigned CLK_POLLS = 20,
    parameter int unsigned PDB_TICKS = 3,
    parameter int unsigned CAL_TICKS = 5,
    parameter int unsigned DLL_TICKS = 30
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_on,
    input  logic       start_off,
    input  logic       tick_us,
    input  logic       tick_ms,
    input  logic       clk_rdy_i,
    input  logic       cal_done_i,
    input  logic       dll_rdy_i,
    output logic       int_clk_en_o,
    output logic       clk_out_en_o,
    output logic       pad_pwr_o,
    output logic       dll_en_o,
    output logic       busy_o,
    output logic       done_o,
    output logic [1:0] err_o
);

    localparam int unsigned MAX_A = (CLK_POLLS > PDB_TICKS) ? CLK_POLLS : PDB_TICKS;
    localparam int unsigned MAX_B = (CAL_TICKS > DLL_TICKS) ? CAL_TICKS : DLL_TICKS;
    localparam int unsigned MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned CNT_W = $clog2(MAX_T + 1);

    logic             tmr_clr;
    logic             tmr_use_ms;
    logic [CNT_W-1:0] tmr_limit;
    logic             tmr_tick;
    logic             tmr_hit;

    pwrseq_tick_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .use_ms  (tmr_use_ms),
        .tick_us (tick_us),
        .tick_ms (tick_ms),
        .limit   (tmr_limit),
        .tick_o  (tmr_tick),
        .hit_o   (tmr_hit)
    );

    pwrseq_fsm #(
        .CNT_W     (CNT_W),
        .CLK_POLLS (CLK_POLLS),
        .PDB_TICKS (PDB_TICKS),
        .CAL_TICKS (CAL_TICKS),
        .DLL_TICKS (DLL_TICKS)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_on     (start_on),
        .start_off    (start_off),
        .tick         (tmr_tick),
        .hit          (tmr_hit),
        .clk_rdy_i    (clk_rdy_i),
        .cal_done_i   (cal_done_i),
        .dll_rdy_i    (dll_rdy_i),
        .tmr_clr      (tmr_clr),
        .tmr_use_ms   (tmr_use_ms),
        .tmr_limit    (tmr_limit),
        .int_clk_en_o (int_clk_en_o),
        .clk_out_en_o (clk_out_en_o),
        .pad_pwr_o    (pad_pwr_o),
        .dll_en_o     (dll_en_o),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .err_o        (err_o)
    );

endmodule

// File: tb/tb_phy_pwr_seq.sv
module tb_phy_pwr_seq;

    localparam int POLLS = 20;
    localparam int PDB   = 3;
    localparam int CAL   = 5;
    localparam int DLL   = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_on = 1'b0, start_off = 1'b0;
    logic tick_us = 1'b0, tick_ms = 1'b0;
    logic clk_rdy_i = 1'b0, cal_done_i = 1'b0, dll_rdy_i = 1'b0;
    logic int_clk_en_o, clk_out_en_o, pad_pwr_o, dll_en_o, busy_o, done_o;
    logic [1:0] err_o;

    int n_chk = 0;
    int n_bad = 0;
    bit noisy = 1'b0;

    always #2 clk = ~clk;

    phy_pwr_seq dut (
        .clk(clk), .rst_n(rst_n), .start_on(start_on), .start_off(start_off),
        .tick_us(tick_us), .tick_ms(tick_ms), .clk_rdy_i(clk_rdy_i),
        .cal_done_i(cal_done_i), .dll_rdy_i(dll_rdy_i),
        .int_clk_en_o(int_clk_en_o), .clk_out_en_o(clk_out_en_o),
        .pad_pwr_o(pad_pwr_o), .dll_en_o(dll_en_o), .busy_o(busy_o),
        .done_o(done_o), .err_o(err_o)
    );

    function automatic int exp_code(int k, bit cal, bit dll);
        if (k >= POLLS) return 1;
        if (!cal)       return 2;
        if (!dll)       return 3;
        return 0;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic gap();
        repeat ($urandom_range(0, 2)) @(negedge clk);
    endtask

    // one tick pulse; stray commands ride along when noisy (R7)
    task automatic pulse(bit ms);
        gap();
        @(negedge clk);
        if (ms) tick_ms = 1'b1; else tick_us = 1'b1;
        if (noisy) begin
            start_on  = $urandom_range(0, 1);
            start_off = $urandom_range(0, 1);
        end
        @(negedge clk);
        tick_ms = 1'b0; tick_us = 1'b0;
        start_on = 1'b0; start_off = 1'b0;
    endtask

    task automatic run_on(int k, bit cal, bit dll);
        int e;
        int pre_out;
        e = exp_code(k, cal, dll);
        pre_out = clk_out_en_o;
        @(negedge clk) start_on = 1'b1;
        @(negedge clk) start_on = 1'b0;
        chk("R2", "busy after accept", busy_o, 1);
        chk("R2", "pad off after accept", pad_pwr_o, 0);
        chk("R2", "dll off after accept", dll_en_o, 0);
        @(negedge clk);
        chk("R2", "int clk enable", int_clk_en_o, 1);
        for (int i = 0; i < POLLS; i++) begin
            clk_rdy_i = (i >= k);
            pulse(1'b1);
            if (i >= k) break;
            if (i < POLLS - 1) chk("R3", "no early done while polling", done_o, 0);
        end
        clk_rdy_i = 1'b0;
        if (e == 1) begin
            chk("R3", "clock timeout done", done_o, 1);
            chk("R3", "clock timeout code", err_o, 1);
            chk("R9", "clk_out kept on clock timeout", clk_out_en_o, pre_out);
            chk("R9", "int clk kept on clock timeout", int_clk_en_o, 1);
            chk("R9", "pad off on clock timeout", pad_pwr_o, 0);
            @(negedge clk);
            chk("R8", "done single cycle", done_o, 0);
            return;
        end
        chk("R4", "clk_out after ready", clk_out_en_o, 1);
        for (int i = 0; i < PDB - 1; i++) pulse(1'b0);
        chk("R4", "pad still off before last wait tick", pad_pwr_o, 0);
        pulse(1'b0);
        chk("R4", "pad on after wait", pad_pwr_o, 1);
        @(negedge clk) start_off = 1'b1;
        @(negedge clk) start_off = 1'b0;
        chk("R7", "off ignored while busy: pad", pad_pwr_o, 1);
        chk("R7", "off ignored while busy: busy", busy_o, 1);
        chk("R7", "off ignored while busy: done", done_o, 0);
        cal_done_i = !cal;
        for (int i = 0; i < CAL - 1; i++) pulse(1'b0);
        chk("R5", "no done before cal sample", done_o, 0);
        cal_done_i = cal;
        pulse(1'b0);
        cal_done_i = 1'b0;
        if (e == 2) begin
            chk("R5", "cal timeout done", done_o, 1);
            chk("R5", "cal timeout code", err_o, 2);
            chk("R9", "pad off on cal timeout", pad_pwr_o, 0);
            chk("R9", "clk_out kept on cal timeout", clk_out_en_o, 1);
            @(negedge clk);
            chk("R8", "done single cycle", done_o, 0);
            return;
        end
        chk("R6", "dll enable after cal", dll_en_o, 1);
        chk("R6", "still busy in dll wait", busy_o, 1);
        dll_rdy_i = !dll;
        for (int i = 0; i < DLL - 1; i++) pulse(1'b0);
        chk("R6", "no done before dll sample", done_o, 0);
        dll_rdy_i = dll;
        pulse(1'b0);
        dll_rdy_i = 1'b0;
        chk("R8", "done at end", done_o, 1);
        chk("R6", "result code", err_o, e);
        chk("R8", "not busy at done", busy_o, 0);
        chk("R6", "dll enable level at end", dll_en_o, (e == 0) ? 1 : 0);
        if (e == 3) chk("R9", "pad off on dll timeout", pad_pwr_o, 0);
        @(negedge clk);
        chk("R8", "done single cycle", done_o, 0);
    endtask

    task automatic run_off(bit both);
        int pre_int, pre_out;
        pre_int = int_clk_en_o;
        pre_out = clk_out_en_o;
        @(negedge clk);
        start_off = 1'b1;
        start_on  = both;
        @(negedge clk);
        start_off = 1'b0; start_on = 1'b0;
        chk(both ? "R10" : "R1", "off done", done_o, 1);
        chk(both ? "R10" : "R1", "off code", err_o, 0);
        chk(both ? "R10" : "R1", "off busy", busy_o, 0);
        chk("R1", "off pad", pad_pwr_o, 0);
        chk("R1", "off dll", dll_en_o, 0);
        chk("R1", "off keeps int clk", int_clk_en_o, pre_int);
        chk("R1", "off keeps clk_out", clk_out_en_o, pre_out);
        @(negedge clk);
        chk("R8", "off done single cycle", done_o, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual still running, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "reset int clk", int_clk_en_o, 0);
        chk("R11", "reset clk_out", clk_out_en_o, 0);
        chk("R11", "reset pad", pad_pwr_o, 0);
        chk("R11", "reset dll", dll_en_o, 0);
        chk("R11", "reset busy", busy_o, 0);
        chk("R11", "reset done", done_o, 0);
        chk("R11", "reset code", err_o, 0);

        run_off(1'b0);
        run_on(0, 1'b1, 1'b1);
        run_off(1'b1);
        run_on(POLLS - 1, 1'b1, 1'b1);
        run_off(1'b0);
        run_on(POLLS, 1'b1, 1'b1);
        run_on(2, 1'b0, 1'b1);
        run_on(1, 1'b1, 1'b0);

        for (int it = 0; it < 40; it++) begin
            int k;
            bit cal, dll;
            k   = $urandom_range(0, POLLS + 4);
            cal = ($urandom_range(0, 3) != 0);
            dll = ($urandom_range(0, 3) != 0);
            noisy = $urandom_range(0, 1);
            run_on(k, cal, dll);
            noisy = 1'b0;
            if ($urandom_range(0, 2) == 0) run_off($urandom_range(0, 1));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule